// File: doc/BRIEF.md
# Message-signalled interrupt generator

This block turns interrupt request lines from up to 32 sources into memory-write messages. Each message is an address plus a 32-bit data word, and it leaves the block on a valid/ready port. The block takes its settings from capability registers held elsewhere: a global enable, the target address, a 16-bit data pattern, the enabled message count (as a log2 value) and a per-vector mask.

A request is the rising edge of a source's level. The edge is noted as a pending bit. A pending vector that is not masked is sent when the output port is free, and its pending bit is cleared when its message is loaded. A masked vector keeps its pending bit, so clearing the mask later releases the held message. The vector number is written into the low bits of the data pattern; the number of bits it replaces is set by the enabled message count.

Top module: `msi_msg_engine`

## Requirements
- R1: While reset is held, and in the first cycle after reset, `msg_valid` is 0 and every bit of `pend` is 0.
- R2: A request is only a low-to-high transition of `irq_level[v]`. Holding the level high produces exactly one message. Driving the level low neither produces a message nor clears `pend[v]`.
- R3: A request on a vector whose `cfg_mask` bit is 1 sets `pend[v]` and produces no message.
- R4: A request on an unmasked vector produces one message, and `pend[v]` reads 0 once that message has been loaded.
- R5: `msg_data[31:16]` is zero. `msg_data[15:0]` is `cfg_data` with its low k bits replaced by the low k bits of the vector number. Here k is `cfg_mme`, with values above 5 treated as 5.
- R6: With `ADDR64`=1, `msg_addr` is {`cfg_addr_hi`, `cfg_addr_lo`}. With `ADDR64`=0, `msg_addr` is `cfg_addr_lo` zero-extended to 64 bits.
- R7: Clearing the mask bit of a vector whose `pend` bit is set produces a message for that vector without any new request.
- R8: Edges that occur while `cfg_enable` is 0 are discarded: they set no pending bit. No message is loaded while `cfg_enable` is 0.
- R9: When several unmasked vectors are pending, the lowest-numbered vector is sent first. Exactly one message is sent per accepted handshake.
- R10: Once `msg_valid` is 1, it stays 1 with `msg_addr` and `msg_data` unchanged until `msg_ready` is 1 at a clock edge. Requests that arrive in the meantime are held in `pend`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_enable | input | 1 | Global message enable |
| cfg_mme | input | 3 | Log2 of the enabled message count |
| cfg_addr_lo | input | 32 | Low word of the target address |
| cfg_addr_hi | input | 32 | High word of the target address (used only when ADDR64=1) |
| cfg_data | input | 16 | Data pattern |
| cfg_mask | input | NVEC | Per-vector mask, 1 = masked |
| irq_level | input | NVEC | Request levels, one per vector |
| pend | output | NVEC | Pending bits |
| msg_valid | output | 1 | Message present |
| msg_ready | input | 1 | Message accepted by the consumer |
| msg_addr | output | 64 | Message address |
| msg_data | output | 32 | Message data |

## Verification
Three pairs of events can meet in one cycle, and each pair is provoked on purpose:
- A new request can arrive while an earlier message is stalled. The bench holds `msg_ready` low and raises another vector. It then checks that the pending bit is set and that the held message does not change.
- Several vectors can become ready in the same cycle. The bench clears the mask on three pending vectors at once and checks the order in which they come out.
- A handshake can coincide with the next load. The bench checks that back-to-back messages are neither lost nor duplicated.

A behavioural reference model is compared with the outputs and pending bits on every cycle.

// File: rtl/msi_msg_engine.sv
module msi_msg_engine #(
  parameter int NVEC   = 32,
  parameter bit ADDR64 = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_enable,
  input  logic [2:0]      cfg_mme,
  input  logic [31:0]     cfg_addr_lo,
  input  logic [31:0]     cfg_addr_hi,
  input  logic [15:0]     cfg_data,
  input  logic [NVEC-1:0] cfg_mask,
  input  logic [NVEC-1:0] irq_level,
  output logic [NVEC-1:0] pend,
  output logic            msg_valid,
  input  logic            msg_ready,
  output logic [63:0]     msg_addr,
  output logic [31:0]     msg_data
);
  localparam int VW = (NVEC > 1) ? $clog2(NVEC) : 1;

  logic [NVEC-1:0] lvl_q, pend_q, edge_v, ready_v, clr_v;
  logic [VW-1:0]   pick, vec_q;
  logic            any, take;
  logic [2:0]      mme_c;
  logic [15:0]     vmask, splice;

  assign edge_v  = irq_level & ~lvl_q & {NVEC{cfg_enable}};
  assign ready_v = pend_q & ~cfg_mask;

  always_comb begin
    pick = '0;
    any  = 1'b0;
    for (int i = NVEC - 1; i >= 0; i--) begin
      if (ready_v[i]) begin
        pick = VW'(i);
        any  = 1'b1;
      end
    end
  end

  assign take   = cfg_enable && any && (!msg_valid || msg_ready);
  assign clr_v  = take ? (NVEC'(1) << pick) : '0;
  assign mme_c  = (cfg_mme > 3'd5) ? 3'd5 : cfg_mme;
  assign vmask  = 16'((32'd1 << mme_c) - 32'd1);
  assign splice = (cfg_data & ~vmask) | (16'(pick) & vmask);
  assign pend   = pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q     <= '0;
      pend_q    <= '0;
      msg_valid <= 1'b0;
      msg_addr  <= '0;
      msg_data  <= '0;
      vec_q     <= '0;
    end else begin
      lvl_q  <= irq_level;
      pend_q <= (pend_q & ~clr_v) | edge_v;
      if (take) begin
        msg_valid <= 1'b1;
        msg_addr  <= ADDR64 ? {cfg_addr_hi, cfg_addr_lo} : {32'h0, cfg_addr_lo};
        msg_data  <= {16'h0, splice};
        vec_q     <= pick;
      end else if (msg_ready) begin
        msg_valid <= 1'b0;
      end
    end
  end

  p_hold_until_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data)));

  p_upper_data_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> (msg_data[31:16] == 16'h0));

  p_new_pend_needs_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|(pend_q & ~$past(pend_q))) |-> $past(cfg_enable));

  p_loaded_vec_unmasked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && (!$past(msg_valid) || $past(msg_ready)))
      |-> ((($past(cfg_mask) >> vec_q) & NVEC'(1)) == '0));
endmodule

// File: tb/tb_msi_msg_engine.sv
module tb_msi_msg_engine;
  localparam int NVEC = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_enable = 1'b1;
  logic [2:0] cfg_mme = 3'd3;
  logic [31:0] cfg_addr_lo = 32'hFEE0_1000, cfg_addr_hi = 32'h0000_0001;
  logic [15:0] cfg_data = 16'h1230;
  logic [NVEC-1:0] cfg_mask = '0, irq_level = '0;
  logic [NVEC-1:0] pend;
  logic msg_valid, msg_ready = 1'b1;
  logic [63:0] msg_addr;
  logic [31:0] msg_data;

  int total = 0, bad = 0;
  bit finished = 0;

  msi_msg_engine #(.NVEC(NVEC), .ADDR64(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_mme(cfg_mme),
    .cfg_addr_lo(cfg_addr_lo), .cfg_addr_hi(cfg_addr_hi), .cfg_data(cfg_data),
    .cfg_mask(cfg_mask), .irq_level(irq_level), .pend(pend),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_addr(msg_addr), .msg_data(msg_data));

  always #10 clk = ~clk;

  function automatic logic [31:0] exp_data(int v, int mme, logic [15:0] d);
    int k = (mme > 5) ? 5 : mme;
    logic [15:0] m = 16'((1 << k) - 1);
    return {16'h0, (d & ~m) | (16'(v) & m)};
  endfunction

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  logic [NVEC-1:0] m_pend = '0, m_prev = '0;
  logic m_valid = 1'b0;
  logic [63:0] m_addr = '0;
  logic [31:0] m_data = '0;

  always @(posedge clk) begin : model
    int pk;
    if (!rst_n) begin
      m_pend = '0; m_prev = '0; m_valid = 1'b0;
    end else begin
      pk = -1;
      if (cfg_enable && (!m_valid || msg_ready))
        for (int v = 0; v < NVEC; v++)
          if (pk < 0 && m_pend[v] && !cfg_mask[v]) pk = v;
      for (int v = 0; v < NVEC; v++) begin
        if (pk == v) m_pend[v] = 1'b0;
        if (irq_level[v] && !m_prev[v] && cfg_enable) m_pend[v] = 1'b1;
      end
      if (pk >= 0) begin
        m_valid = 1'b1;
        m_addr  = {cfg_addr_hi, cfg_addr_lo};
        m_data  = exp_data(pk, cfg_mme, cfg_data);
      end else if (msg_ready) m_valid = 1'b0;
      m_prev = irq_level;
    end
  end

  always @(negedge clk) if (rst_n && !finished) begin
    chk(msg_valid == m_valid, "model(R9) valid", 64'(msg_valid), 64'(m_valid));
    chk(pend == m_pend, "model(R2) pend", 64'(pend), 64'(m_pend));
    if (m_valid) begin
      chk(msg_addr == m_addr, "model(R6) addr", msg_addr, m_addr);
      chk(msg_data == m_data, "model(R5) data", 64'(msg_data), 64'(m_data));
    end
  end

  task automatic pulse(int v);
    irq_level[v] = 1'b1;
    @(negedge clk);
    irq_level[v] = 1'b0;
    @(negedge clk);
  endtask

  task automatic expect_msg(int v, string tag);
    int n = 0;
    while (!msg_valid && n < 20) begin @(negedge clk); n++; end
    chk(msg_valid, {tag, " message appears"}, 64'(msg_valid), 64'd1);
    chk(msg_data == exp_data(v, cfg_mme, cfg_data), {tag, " data"},
        64'(msg_data), 64'(exp_data(v, cfg_mme, cfg_data)));
    chk(msg_addr == {cfg_addr_hi, cfg_addr_lo}, {tag, " R6 address"},
        msg_addr, {cfg_addr_hi, cfg_addr_lo});
    @(negedge clk);
  endtask

  task automatic no_msg(int n, string tag);
    bit seen = 0;
    for (int i = 0; i < n; i++) begin
      if (msg_valid) seen = 1;
      @(negedge clk);
    end
    chk(!seen, tag, 64'(seen), 64'd0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] ha;
    logic [31:0] hd;
    repeat (3) @(negedge clk);
    chk(!msg_valid && pend == '0, "R1 during reset", {31'h0, msg_valid, pend}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!msg_valid && pend == '0, "R1 after reset", {31'h0, msg_valid, pend}, 64'd0);

    pulse(5);
    expect_msg(5, "R4 single vector");
    chk(pend[5] == 1'b0, "R4 pend cleared", 64'(pend), 64'd0);

    irq_level[5] = 1'b1;
    expect_msg(5, "R2 first edge");
    no_msg(8, "R2 held high no repeat");
    irq_level[5] = 1'b0;
    no_msg(4, "R2 falling no message");
    pulse(5);
    expect_msg(5, "R2 second edge");

    cfg_mask[7] = 1'b1;
    pulse(7);
    repeat (3) @(negedge clk);
    chk(pend[7] && !msg_valid, "R3 masked held", {31'h0, msg_valid, pend}, 64'h80);
    repeat (3) @(negedge clk);
    chk(pend[7] == 1'b1, "R2 low keeps pend", 64'(pend), 64'h80);
    cfg_mask[7] = 1'b0;
    expect_msg(7, "R7 unmask replay");
    chk(pend[7] == 1'b0, "R4 pend after replay", 64'(pend), 64'd0);

    cfg_enable = 1'b0;
    pulse(9);
    repeat (3) @(negedge clk);
    chk(pend == '0 && !msg_valid, "R8 disabled ignored", {31'h0, msg_valid, pend}, 64'd0);
    cfg_enable = 1'b1;
    no_msg(5, "R8 no late message");

    cfg_mask[2] = 1'b1; cfg_mask[4] = 1'b1; cfg_mask[6] = 1'b1;
    irq_level[6] = 1'b1; irq_level[2] = 1'b1; irq_level[4] = 1'b1;
    @(negedge clk);
    irq_level = '0;
    repeat (2) @(negedge clk);
    chk(pend == 32'h54, "R3 three pending", 64'(pend), 64'h54);
    cfg_mask = '0;
    expect_msg(2, "R9 first lowest");
    expect_msg(4, "R9 second");
    expect_msg(6, "R9 third");
    no_msg(4, "R9 no extra");

    msg_ready = 1'b0;
    pulse(3);
    @(negedge clk);
    ha = msg_addr; hd = msg_data;
    pulse(1);
    cfg_data = 16'hFFFF;
    repeat (3) @(negedge clk);
    chk(msg_valid && msg_addr == ha && msg_data == hd, "R10 held stable",
        64'(msg_data), 64'(hd));
    chk(pend[1] == 1'b1, "R10 request pending meanwhile", 64'(pend), 64'h2);
    cfg_data = 16'h1230;
    msg_ready = 1'b1;
    expect_msg(3, "R10 stalled message");
    expect_msg(1, "R10 next after stall");

    cfg_mme = 3'd0;
    pulse(3);
    expect_msg(3, "R5 mme0");
    cfg_mme = 3'd5;
    pulse(31);
    expect_msg(31, "R5 mme5");
    cfg_mme = 3'd7;
    cfg_data = 16'hA5A5;
    pulse(18);
    expect_msg(18, "R5 mme clamp");
    chk(msg_data[31:16] == 16'h0, "R5 upper zero", 64'(msg_data), 64'(msg_data[15:0]));

    repeat (3) @(negedge clk);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule